// File: doc/BRIEF.md
# Host/Local Mailbox Register File

This block holds sixteen 8-bit data slots that two agents share: a host side and a local side. Host requests reach it as already decoded I/O reads and writes carrying a slot index. Local requests use a plain register port of the same shape. Each side also chooses a space: data slots or status registers. Slots 1 to 15 are ordinary shared cells. Either side may write them and either side may read them.

Slot 0 is different. It is a pair of one-way registers at a single index. Whatever the host writes there is seen only by the local side, and whatever the local side writes there is seen only by the host. Each direction has a full flag and a write-valid flag. A started flag records which side began a transfer first. Because of this, two agents that write slot 0 at nearly the same time can each learn from status whether their own write counted.

There are four 8-bit status registers. The host reads them by index, and the local side can read them too. Status register 1 holds the slot-0 flags and is maintained by hardware. Status registers 2 to 4 are general status bytes written by the local side.

Top module: `mbox_regfile`

## Requirements
- R1: In the data space (space=0), a write to slot 1..15 from either side is returned by a later read of that slot from either side.
- R2: In the data space, a host write to slot 0 is returned only by local reads of slot 0, and a local write to slot 0 is returned only by host reads of slot 0.
- R3: When both sides write the same slot 1..15 in the same cycle, the host data is stored and the local write is dropped.
- R4: On each side, the read-valid output is high exactly one cycle after a read request. The read data returned is the slot content as it stood in the request cycle, before any write made in that same cycle.
- R5: In the status space (space=1), index bits [1:0] = k select status register k+1. Status register 1 has these bits: bit0 = host-to-local full, bit1 = local-to-host full, bit2 = host write valid, bit3 = local write valid. Bits 7:4 read as zero.
- R6: A write to slot 0 sets the full flag for its direction. A read of slot 0 by the receiving side clears that flag and also clears the sender's started flag.
- R7: A write to slot 0 while the other side's started flag is set still stores its data, but it clears the writer's valid flag. A winning write sets the writer's valid flag and started flag, and the started flag stays set until the receiver reads slot 0.
- R8: When both sides write slot 0 in the same cycle and the local started flag is clear, the host wins: host valid becomes 1 and local valid becomes 0.
- R9: A local write in the status space with index bits [1:0] = 1..3 updates status register 2..4. Local writes to status register 1 and all host writes in the status space change nothing.
- R10: Reset clears every flag and status registers 2..4 to zero. It clears both read-valid outputs. The contents of the data slots are left undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host write request |
| host_rd_i | input | 1 | Host read request |
| host_space_i | input | 1 | Host space: 0 data, 1 status |
| host_idx_i | input | 4 | Host slot / status index |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data |
| host_rvalid_o | output | 1 | Host read data valid |
| loc_wr_i | input | 1 | Local write request |
| loc_rd_i | input | 1 | Local read request |
| loc_space_i | input | 1 | Local space: 0 data, 1 status |
| loc_idx_i | input | 4 | Local slot / status index |
| loc_wdata_i | input | 8 | Local write data |
| loc_rdata_o | output | 8 | Local read data |
| loc_rvalid_o | output | 1 | Local read data valid |

## Verification
Any wrong flag or arbitration state shows up on the next status-1 read from either side. The bench issues such reads often in random traffic, so a corrupted valid or full bit surfaces within a few cycles. A wrong slot-0 route, or a lost collision with the host, appears as wrong read data one cycle after the next read of the affected slot. Read-latency faults show up on the very next cycle as a misplaced valid strobe.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic {
    SP_DATA = 1'b0,
    SP_STAT = 1'b1
  } space_e;

  // status register 1 layout, LSB first: h2s_full, s2h_full, host_valid, loc_valid
  typedef struct packed {
    logic loc_valid;
    logic host_valid;
    logic s2h_full;
    logic h2s_full;
  } x0_flags_t;

  localparam int unsigned FLAG_W = $bits(x0_flags_t);
endpackage

// File: rtl/mbox_cells.sv
module mbox_cells #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 16,
  parameter int unsigned IW   = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               h_we_i,
  input  logic [IW-1:0]      h_idx_i,
  input  logic [DW-1:0]      h_wd_i,
  input  logic               l_we_i,
  input  logic [IW-1:0]      l_idx_i,
  input  logic [DW-1:0]      l_wd_i,
  output logic [NREG*DW-1:0] cells_o
);
  assign cells_o[DW-1:0] = '0;  // slot 0 lives in mbox_xfer0

  for (genvar g = 1; g < NREG; g++) begin : g_cell
    logic [DW-1:0] q;
    logic h_hit, l_hit;
    assign h_hit = h_we_i && (h_idx_i == IW'(g));
    assign l_hit = l_we_i && (l_idx_i == IW'(g));
    // contents undefined after reset; host wins same-cycle collision
    always_ff @(posedge clk_i) begin
      if (h_hit)      q <= h_wd_i;
      else if (l_hit) q <= l_wd_i;
    end
    assign cells_o[g*DW +: DW] = q;
  end
endmodule

// File: rtl/mbox_xfer0.sv
module mbox_xfer0
  import mbox_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h_wr_i,
  input  logic          h_rd_i,
  input  logic [DW-1:0] h_wd_i,
  input  logic          l_wr_i,
  input  logic          l_rd_i,
  input  logic [DW-1:0] l_wd_i,
  output logic [DW-1:0] h2s_o,
  output logic [DW-1:0] s2h_o,
  output x0_flags_t     flags_o,
  output logic          h_busy_o,
  output logic          l_busy_o
);
  logic h_win, l_win;
  x0_flags_t flags_q;
  logic h_busy_q, l_busy_q;

  assign h_win = h_wr_i && !l_busy_q;
  assign l_win = l_wr_i && !h_busy_q && !h_win;

  always_ff @(posedge clk_i) begin
    if (h_wr_i) h2s_o <= h_wd_i;
    if (l_wr_i) s2h_o <= l_wd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q  <= '0;
      h_busy_q <= 1'b0;
      l_busy_q <= 1'b0;
    end else begin
      if (h_wr_i)      flags_q.h2s_full <= 1'b1;
      else if (l_rd_i) flags_q.h2s_full <= 1'b0;
      if (l_wr_i)      flags_q.s2h_full <= 1'b1;
      else if (h_rd_i) flags_q.s2h_full <= 1'b0;
      if (h_wr_i) flags_q.host_valid <= h_win;
      if (l_wr_i) flags_q.loc_valid  <= l_win;
      if (h_win)       h_busy_q <= 1'b1;
      else if (l_rd_i) h_busy_q <= 1'b0;
      if (l_win)       l_busy_q <= 1'b1;
      else if (h_rd_i) l_busy_q <= 1'b0;
    end
  end

  assign flags_o  = flags_q;
  assign h_busy_o = h_busy_q;
  assign l_busy_o = l_busy_q;
endmodule

// File: rtl/mbox_status.sv
module mbox_status
  import mbox_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned NSTAT = 4,
  parameter int unsigned SW    = $clog2(NSTAT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                l_we_i,
  input  logic [SW-1:0]       l_sel_i,
  input  logic [DW-1:0]       l_wd_i,
  input  x0_flags_t           flags_i,
  output logic [NSTAT*DW-1:0] stat_o
);
  assign stat_o[DW-1:0] = DW'(flags_i);

  for (genvar k = 1; k < NSTAT; k++) begin : g_stat
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= '0;
      else if (l_we_i && l_sel_i == SW'(k))    q <= l_wd_i;
    end
    assign stat_o[k*DW +: DW] = q;
  end
endmodule

// File: rtl/mbox_regfile.sv
module mbox_regfile
  import mbox_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned NREG  = 16,
  parameter int unsigned NSTAT = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    host_wr_i,
  input  logic                    host_rd_i,
  input  logic                    host_space_i,
  input  logic [$clog2(NREG)-1:0] host_idx_i,
  input  logic [DW-1:0]           host_wdata_i,
  output logic [DW-1:0]           host_rdata_o,
  output logic                    host_rvalid_o,
  input  logic                    loc_wr_i,
  input  logic                    loc_rd_i,
  input  logic                    loc_space_i,
  input  logic [$clog2(NREG)-1:0] loc_idx_i,
  input  logic [DW-1:0]           loc_wdata_i,
  output logic [DW-1:0]           loc_rdata_o,
  output logic                    loc_rvalid_o
);
  localparam int unsigned IW = $clog2(NREG);
  localparam int unsigned SW = $clog2(NSTAT);

  logic h_data, l_data, h_x0, l_x0;
  logic [NREG*DW-1:0]  cells_w;
  logic [NSTAT*DW-1:0] stat_w;
  logic [DW-1:0] h2s_w, s2h_w;
  logic [DW-1:0] h_mux, l_mux;
  x0_flags_t flags_w;
  logic h_busy_w, l_busy_w;

  assign h_data = (space_e'(host_space_i) == SP_DATA);
  assign l_data = (space_e'(loc_space_i) == SP_DATA);
  assign h_x0   = h_data && (host_idx_i == '0);
  assign l_x0   = l_data && (loc_idx_i == '0);

  mbox_cells #(.DW(DW), .NREG(NREG), .IW(IW)) u_cells (
    .clk_i   (clk_i),
    .h_we_i  (host_wr_i && h_data),
    .h_idx_i (host_idx_i),
    .h_wd_i  (host_wdata_i),
    .l_we_i  (loc_wr_i && l_data),
    .l_idx_i (loc_idx_i),
    .l_wd_i  (loc_wdata_i),
    .cells_o (cells_w)
  );

  mbox_xfer0 #(.DW(DW)) u_xfer0 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .h_wr_i   (host_wr_i && h_x0),
    .h_rd_i   (host_rd_i && h_x0),
    .h_wd_i   (host_wdata_i),
    .l_wr_i   (loc_wr_i && l_x0),
    .l_rd_i   (loc_rd_i && l_x0),
    .l_wd_i   (loc_wdata_i),
    .h2s_o    (h2s_w),
    .s2h_o    (s2h_w),
    .flags_o  (flags_w),
    .h_busy_o (h_busy_w),
    .l_busy_o (l_busy_w)
  );

  mbox_status #(.DW(DW), .NSTAT(NSTAT), .SW(SW)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .l_we_i  (loc_wr_i && !l_data),
    .l_sel_i (loc_idx_i[SW-1:0]),
    .l_wd_i  (loc_wdata_i),
    .flags_i (flags_w),
    .stat_o  (stat_w)
  );

  always_comb begin
    if (!h_data)   h_mux = stat_w[host_idx_i[SW-1:0]*DW +: DW];
    else if (h_x0) h_mux = s2h_w;
    else           h_mux = cells_w[host_idx_i*DW +: DW];
    if (!l_data)   l_mux = stat_w[loc_idx_i[SW-1:0]*DW +: DW];
    else if (l_x0) l_mux = h2s_w;
    else           l_mux = cells_w[loc_idx_i*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_rvalid_o <= 1'b0;
      loc_rvalid_o  <= 1'b0;
      host_rdata_o  <= '0;
      loc_rdata_o   <= '0;
    end else begin
      host_rvalid_o <= host_rd_i;
      loc_rvalid_o  <= loc_rd_i;
      if (host_rd_i) host_rdata_o <= h_mux;
      if (loc_rd_i)  loc_rdata_o  <= l_mux;
    end
  end
endmodule

// File: rtl/mbox_regfile_chk.sv
module mbox_regfile_chk
  import mbox_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 4,
  parameter int unsigned SW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_wr_i,
  input logic          host_rd_i,
  input logic          host_space_i,
  input logic [IW-1:0] host_idx_i,
  input logic [DW-1:0] host_rdata_o,
  input logic          host_rvalid_o,
  input logic          loc_wr_i,
  input logic          loc_rd_i,
  input logic          loc_space_i,
  input logic [IW-1:0] loc_idx_i,
  input logic          loc_rvalid_o,
  input x0_flags_t     flags_w,
  input logic          h_busy_w,
  input logic          l_busy_w
);
  logic hw0, hr0, lw0, hst1;
  assign hw0  = host_wr_i && !host_space_i && host_idx_i == '0;
  assign hr0  = host_rd_i && !host_space_i && host_idx_i == '0;
  assign lw0  = loc_wr_i && !loc_space_i && loc_idx_i == '0;
  assign hst1 = host_rd_i && host_space_i && host_idx_i[SW-1:0] == '0;

  assert_host_rvalid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i |=> host_rvalid_o);
  assert_host_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rd_i |=> !host_rvalid_o);
  assert_loc_rvalid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_rd_i |=> loc_rvalid_o);
  assert_stat1_pad_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hst1 |=> host_rdata_o[DW-1:4] == '0);
  assert_h2s_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw0 |=> flags_w.h2s_full);
  assert_s2h_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hr0 && !lw0) |=> !flags_w.s2h_full);
  assert_late_loses_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw0 && l_busy_w) |=> !flags_w.host_valid);
  assert_one_owner_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(h_busy_w && l_busy_w));
  assert_tie_host_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw0 && lw0 && !l_busy_w) |=> (flags_w.host_valid && !flags_w.loc_valid));
endmodule

bind mbox_regfile mbox_regfile_chk #(.DW(DW), .IW(IW), .SW(SW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .host_wr_i     (host_wr_i),
  .host_rd_i     (host_rd_i),
  .host_space_i  (host_space_i),
  .host_idx_i    (host_idx_i),
  .host_rdata_o  (host_rdata_o),
  .host_rvalid_o (host_rvalid_o),
  .loc_wr_i      (loc_wr_i),
  .loc_rd_i      (loc_rd_i),
  .loc_space_i   (loc_space_i),
  .loc_idx_i     (loc_idx_i),
  .loc_rvalid_o  (loc_rvalid_o),
  .flags_w       (flags_w),
  .h_busy_w      (h_busy_w),
  .l_busy_w      (l_busy_w)
);

// File: tb/mbox_regfile_bench.sv
`timescale 1ns/1ps
module mbox_regfile_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic hwr, hrd, hsp, lwr, lrd, lsp;
  logic [3:0] hidx, lidx;
  logic [7:0] hwd, lwd, hrdata, lrdata;
  logic hrv, lrv;

  mbox_regfile u_mbox_regfile (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(hwr), .host_rd_i(hrd), .host_space_i(hsp), .host_idx_i(hidx),
    .host_wdata_i(hwd), .host_rdata_o(hrdata), .host_rvalid_o(hrv),
    .loc_wr_i(lwr), .loc_rd_i(lrd), .loc_space_i(lsp), .loc_idx_i(lidx),
    .loc_wdata_i(lwd), .loc_rdata_o(lrdata), .loc_rvalid_o(lrv)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model
  logic [7:0] m_data [16];
  bit         m_known[16];
  logic [7:0] m_h2s, m_s2h;
  bit m_h2s_k, m_s2h_k;
  bit m_hf, m_sf, m_hv, m_lv, m_hb, m_lb;
  logic [7:0] m_stat[4];

  function automatic logic [7:0] stat_val(int k);
    if (k == 0) return {4'b0, m_lv, m_hv, m_sf, m_hf};
    return m_stat[k];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string auto_tag(bit sp, logic [3:0] idx);
    if (sp) return "R5";
    if (idx == 0) return "R2";
    return "R1";
  endfunction

  // one cycle: drive at negedge, predict, update model, check at next negedge
  task automatic step(bit h_w, bit h_r, bit h_s, logic [3:0] h_i, logic [7:0] h_d,
                      bit l_w, bit l_r, bit l_s, logic [3:0] l_i, logic [7:0] l_d,
                      string tag);
    logic [7:0] eh, el;
    bit kh, kl, hw0, lw0, hr0, lr0, hwin, lwin;
    string th, tl;
    hwr = h_w; hrd = h_r; hsp = h_s; hidx = h_i; hwd = h_d;
    lwr = l_w; lrd = l_r; lsp = l_s; lidx = l_i; lwd = l_d;
    // predicted read data (R4: pre-write contents)
    kh = 1; eh = 8'h00;
    if (h_s) eh = stat_val(int'(h_i[1:0]));
    else if (h_i == 0) begin eh = m_s2h; kh = m_s2h_k; end
    else begin eh = m_data[h_i]; kh = m_known[h_i]; end
    kl = 1; el = 8'h00;
    if (l_s) el = stat_val(int'(l_i[1:0]));
    else if (l_i == 0) begin el = m_h2s; kl = m_h2s_k; end
    else begin el = m_data[l_i]; kl = m_known[l_i]; end
    // model update
    hw0 = h_w && !h_s && h_i == 0;  lw0 = l_w && !l_s && l_i == 0;
    hr0 = h_r && !h_s && h_i == 0;  lr0 = l_r && !l_s && l_i == 0;
    hwin = hw0 && !m_lb;
    lwin = lw0 && !m_hb && !hwin;
    if (h_w && !h_s && h_i != 0) begin m_data[h_i] = h_d; m_known[h_i] = 1; end
    if (l_w && !l_s && l_i != 0 && !(h_w && !h_s && h_i == l_i)) begin
      m_data[l_i] = l_d; m_known[l_i] = 1;
    end
    if (hw0) begin m_h2s = h_d; m_h2s_k = 1; m_hv = hwin; end
    if (lw0) begin m_s2h = l_d; m_s2h_k = 1; m_lv = lwin; end
    if (hw0) m_hf = 1; else if (lr0) m_hf = 0;
    if (lw0) m_sf = 1; else if (hr0) m_sf = 0;
    if (hwin) m_hb = 1; else if (lr0) m_hb = 0;
    if (lwin) m_lb = 1; else if (hr0) m_lb = 0;
    if (l_w && l_s && l_i[1:0] != 0) m_stat[l_i[1:0]] = l_d;
    @(negedge clk);
    th = (tag != "") ? tag : auto_tag(h_s, h_i);
    tl = (tag != "") ? tag : auto_tag(l_s, l_i);
    chk("R4 host rvalid", {7'b0, hrv}, {7'b0, h_r});
    chk("R4 loc rvalid",  {7'b0, lrv}, {7'b0, l_r});
    if (h_r && kh) chk(th, hrdata, eh);
    if (l_r && kl) chk(tl, lrdata, el);
  endtask

  task automatic idle();
    step(0,0,0,0,0, 0,0,0,0,0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 16; i++) begin m_known[i] = 0; m_data[i] = 0; end
    m_h2s = 0; m_s2h = 0; m_h2s_k = 0; m_s2h_k = 0;
    m_hf = 0; m_sf = 0; m_hv = 0; m_lv = 0; m_hb = 0; m_lb = 0;
    for (int i = 0; i < 4; i++) m_stat[i] = 0;
    hwr = 0; hrd = 0; hsp = 0; hidx = 0; hwd = 0;
    lwr = 0; lrd = 0; lsp = 0; lidx = 0; lwd = 0;
    repeat (3) @(negedge clk);
    chk("R10 host rvalid reset", {7'b0, hrv}, 8'h00);
    chk("R10 loc rvalid reset",  {7'b0, lrv}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    // R10: all status zero after reset
    for (int k = 0; k < 4; k++) step(0,1,1,4'(k),0, 0,1,1,4'(k),0, "R10");

    // R1 / R2: directed fills
    for (int s = 1; s < 16; s++) step(1,0,0,4'(s),8'(s*7+3), 0,0,0,0,0, "R1");
    for (int s = 1; s < 16; s++) step(0,1,0,4'(s),0, 0,1,0,4'(s),0, "R1");
    step(1,0,0,0,8'hA5, 0,0,0,0,0, "R2");
    step(0,1,1,0,0, 0,1,0,0,0, "R6");          // full=1, loc sees A5
    step(0,1,1,0,0, 0,0,0,0,0, "R6");          // loc read cleared h2s_full
    // R7: host started, later local write loses
    step(1,0,0,0,8'h11, 0,0,0,0,0, "R7");
    step(0,0,0,0,0, 1,0,0,0,8'h22, "R7");
    step(0,1,1,0,0, 0,1,1,0,0, "R7");          // host_valid=1, loc_valid=0
    step(0,1,0,0,0, 0,1,0,0,0, "R2");          // each side reads other dir
    step(0,0,0,0,0, 1,0,0,0,8'h33, "R7");      // host busy cleared: local wins
    step(1,0,0,0,8'h44, 0,0,0,0,0, "R7");      // host loses to local start
    step(0,1,1,0,0, 0,0,0,0,0, "R7");
    step(0,1,0,0,0, 0,1,0,0,0, "R6");
    step(0,1,1,0,0, 0,0,0,0,0, "R6");
    // R8: tie
    step(1,0,0,0,8'h55, 1,0,0,0,8'h66, "R8");
    step(0,1,1,0,0, 0,0,0,0,0, "R8");
    step(0,1,0,0,0, 0,1,0,0,0, "R8");
    // R3: collision on slot 5
    step(1,0,0,5,8'hC3, 1,0,0,5,8'h3C, "R3");
    step(0,1,0,5,0, 0,1,0,5,0, "R3");
    // R4: read and write same slot same cycle returns old
    step(1,1,0,9,8'h99, 0,1,0,9,0, "R4");
    step(0,1,0,9,0, 0,0,0,0,0, "R4");
    // R9: status 2..4 writes, status1 and host writes ignored
    for (int k = 1; k < 4; k++) step(0,0,0,0,0, 1,0,1,4'(k),8'(k*16+5), "R9");
    step(1,0,1,2,8'hFF, 1,0,1,0,8'hFF, "R9");
    for (int k = 0; k < 4; k++) step(0,1,1,4'(k),0, 0,1,1,4'(k),0, "R9");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      bit a, b, c, d, e, f;
      logic [3:0] hi, li;
      a = ($urandom % 3) == 0; b = ($urandom % 2) == 0; c = ($urandom % 5) == 0;
      d = ($urandom % 3) == 0; e = ($urandom % 2) == 0; f = ($urandom % 5) == 0;
      hi = (($urandom % 3) == 0) ? 4'd0 : 4'($urandom % 16);
      li = (($urandom % 3) == 0) ? 4'd0 : 4'($urandom % 16);
      if (($urandom % 4) == 0) li = hi;
      step(a, b, c, hi, 8'($urandom), d, e, f, li, 8'($urandom), "");
    end
    idle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule